// File: doc/BRIEF.md
# Conversion Result Queue with Drain and Overflow Signalling

This block buffers conversion results between a converter and a processor bus. The converter presents each new result with a one-cycle write strobe, and the block stores it in a small circular queue. The bus side removes results by reading a pop register. A status register reports the fill count and the index of the entry the next pop will return. It also holds two sticky flags: one that marks a dropped result and one that marks data waiting to be drained.

A select bit chooses how draining is signalled. With the bit at 0, the drain flag raises an interrupt request, and software clears the flag by writing 1 to it after reading the queue. With the bit at 1, the drain flag raises a DMA request and clears itself once the queue has been emptied. An overflow request is raised while the overflow flag and its enable are both set. A combined request ORs this overflow request with underflow and trigger-overrun requests that come from neighbouring channels, each behind its own enable.

The register port has two addresses. Address 0 is the status word. Address 1 is the pop register, which returns the head result zero-extended to 32 bits. In the status word, bit 0 is the overflow flag and bit 1 is the drain flag. Bits 11:8 hold the entry count and bits 15:12 hold the pop index. All other bits read as 0.

Top module: `res_fifo_top`

## Requirements
- R1: After reset the status word reads 0 and every request output is low. Each accepted result increments the count (status bits 11:8), and pops return results in arrival order.
- R2: A result that arrives while the count equals DEPTH sets the overflow flag (status bit 0) and is discarded. The count and the stored entries are unchanged.
- R3: A status write with byte enable 0 set and write-data bit 0 at 1 clears the overflow flag. A write with that bit at 0 leaves the flag as it was.
- R4: `ovf_irq_o` is high exactly while the overflow flag and `cfg_ovf_ie_i` are both 1.
- R5: Every accepted result sets the drain flag (status bit 1).
- R6: While the drain flag and `cfg_drn_ie_i` are both 1, `drn_irq_o` is high when `cfg_drn_dma_i` is 0 and `drn_dma_o` is high when it is 1. The two are never high together.
- R7: With `cfg_drn_dma_i`=0, a status write of 1 to bit 1 (byte enable 0 set) clears the drain flag, even while entries remain. With `cfg_drn_dma_i`=1, such a write is ignored, and the flag clears by itself in the cycle the count reaches 0.
- R8: A read of address 1 with any nonzero byte enable pattern on a non-empty queue returns the head entry and decrements the count.
- R9: The pop index (status bits 15:12) names the entry the next pop returns. It advances on each accepted pop and wraps from DEPTH-1 to 0.
- R10: Writes to the count and pop-index fields of the status word have no effect.
- R11: `comb_irq_o` equals `ovf_irq_o` OR (`ext_unf_i` AND `cfg_unf_ie_i`) OR (`ext_tor_i` AND `cfg_tor_ie_i`).
- R12: A pop of an empty queue returns 0 and changes neither the count nor the pop index. If a result is accepted and a pop is accepted in the same cycle, the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_wr_i | input | 1 | Result write strobe from the converter |
| res_data_i | input | DW | Result value |
| reg_en_i | input | 1 | Register access valid |
| reg_we_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | 1 | 0 for status word, 1 for pop register |
| reg_be_i | input | 4 | Byte enables |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cfg_ovf_ie_i | input | 1 | Overflow request enable |
| cfg_drn_ie_i | input | 1 | Drain request enable |
| cfg_drn_dma_i | input | 1 | Drain request select: 0 interrupt, 1 DMA |
| cfg_unf_ie_i | input | 1 | Enable for the external underflow request |
| cfg_tor_ie_i | input | 1 | Enable for the external trigger-overrun request |
| ext_unf_i | input | 1 | Underflow request from a neighbouring channel |
| ext_tor_i | input | 1 | Trigger-overrun request from a neighbouring channel |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| drn_irq_o | output | 1 | Drain interrupt request |
| drn_dma_o | output | 1 | Drain DMA request |
| comb_irq_o | output | 1 | Combined error interrupt request |

## Verification
The hardest case to reach from the ports is a result strobe and a pop in the same cycle while the queue is full. The pop must go through, the result must still be dropped, and the overflow flag must set. The bench reaches this case by filling the queue to DEPTH and then driving one cycle with both the write strobe and a pop read. It also covers the empty-queue variant of the same collision, where the pop is refused and the result is kept. In DMA mode, the bench checks that the automatic drain clear and the software clear attempt do not interfere: it writes 1 to the drain bit while entries remain, then drains the queue one pop at a time.

// File: rtl/res_fifo_pkg.sv
package res_fifo_pkg;
  localparam int CW = 4;
  typedef logic [CW-1:0] cnt_t;

  function automatic cnt_t ptr_adv(cnt_t p, int depth);
    return (p == cnt_t'(depth - 1)) ? '0 : cnt_t'(p + 1'b1);
  endfunction

  function automatic cnt_t cnt_step(cnt_t c, logic up, logic dn);
    case ({up, dn})
      2'b10:   return cnt_t'(c + 1'b1);
      2'b01:   return cnt_t'(c - 1'b1);
      default: return c;
    endcase
  endfunction

  function automatic logic [31:0] stat_word(cnt_t ptr, cnt_t cnt, logic drn, logic ovf);
    return {16'h0000, ptr, cnt, 6'b000000, drn, ovf};
  endfunction
endpackage

// File: rtl/res_fifo_store.sv
module res_fifo_store
  import res_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output cnt_t          cnt_o,
  output cnt_t          rd_ptr_o,
  output logic          full_o,
  output logic          empty_o
);
  cnt_t wr_ptr_q, rd_ptr_q, cnt_q;
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && wr_ptr_q == cnt_t'(gi)) slot_q[gi] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_adv(wr_ptr_q, DEPTH);
      if (pop_i)  rd_ptr_q <= ptr_adv(rd_ptr_q, DEPTH);
      cnt_q <= cnt_step(cnt_q, push_i, pop_i);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!empty_o && rd_ptr_q == cnt_t'(i)) rdata_o = slot_q[i];
    end
  end

  assign cnt_o    = cnt_q;
  assign rd_ptr_o = rd_ptr_q;
  assign full_o   = (cnt_q == cnt_t'(DEPTH));
  assign empty_o  = (cnt_q == '0);
endmodule

// File: rtl/res_fifo_flags.sv
module res_fifo_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic store_acc_i,
  input  logic ovf_evt_i,
  input  logic goes_empty_i,
  input  logic sw_clr_ovf_i,
  input  logic sw_clr_drn_i,
  input  logic dma_sel_i,
  input  logic ovf_ie_i,
  input  logic drn_ie_i,
  output logic ovf_flag_o,
  output logic drn_flag_o,
  output logic ovf_irq_o,
  output logic drn_irq_o,
  output logic drn_dma_o
);
  logic ovf_q, drn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      drn_q <= 1'b0;
    end else begin
      if (ovf_evt_i)         ovf_q <= 1'b1;
      else if (sw_clr_ovf_i) ovf_q <= 1'b0;

      if (store_acc_i)                    drn_q <= 1'b1;
      else if (!dma_sel_i && sw_clr_drn_i) drn_q <= 1'b0;
      else if (dma_sel_i && goes_empty_i)  drn_q <= 1'b0;
    end
  end

  assign ovf_flag_o = ovf_q;
  assign drn_flag_o = drn_q;
  assign ovf_irq_o  = ovf_q & ovf_ie_i;
  assign drn_irq_o  = drn_q & drn_ie_i & ~dma_sel_i;
  assign drn_dma_o  = drn_q & drn_ie_i & dma_sel_i;
endmodule

// File: rtl/res_fifo_top.sv
module res_fifo_top
  import res_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_wr_i,
  input  logic [DW-1:0] res_data_i,
  input  logic          reg_en_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [3:0]    reg_be_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          cfg_ovf_ie_i,
  input  logic          cfg_drn_ie_i,
  input  logic          cfg_drn_dma_i,
  input  logic          cfg_unf_ie_i,
  input  logic          cfg_tor_ie_i,
  input  logic          ext_unf_i,
  input  logic          ext_tor_i,
  output logic          ovf_irq_o,
  output logic          drn_irq_o,
  output logic          drn_dma_o,
  output logic          comb_irq_o
);
  logic          store_req, store_acc, ovf_evt;
  logic          pop_req, pop_acc;
  logic          stat_wr, sw_clr_ovf, sw_clr_drn;
  logic          full, empty, goes_empty;
  logic          ovf_flag, drn_flag;
  cnt_t          cnt, rd_ptr, cnt_nxt;
  logic [DW-1:0] head_data;
  logic          unused_wbits;

  assign store_req  = res_wr_i;
  assign store_acc  = store_req & ~full;
  assign ovf_evt    = store_req & full;
  assign pop_req    = reg_en_i & ~reg_we_i & reg_addr_i & (|reg_be_i);
  assign pop_acc    = pop_req & ~empty;
  assign stat_wr    = reg_en_i & reg_we_i & ~reg_addr_i & reg_be_i[0];
  assign sw_clr_ovf = stat_wr & reg_wdata_i[0];
  assign sw_clr_drn = stat_wr & reg_wdata_i[1];
  assign cnt_nxt    = cnt_step(cnt, store_acc, pop_acc);
  assign goes_empty = (cnt_nxt == '0);
  assign unused_wbits = ^{reg_wdata_i[31:2], reg_be_i[3:1]};

  res_fifo_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (store_acc),
    .pop_i    (pop_acc),
    .wdata_i  (res_data_i),
    .rdata_o  (head_data),
    .cnt_o    (cnt),
    .rd_ptr_o (rd_ptr),
    .full_o   (full),
    .empty_o  (empty)
  );

  res_fifo_flags flags_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .store_acc_i  (store_acc),
    .ovf_evt_i    (ovf_evt),
    .goes_empty_i (goes_empty),
    .sw_clr_ovf_i (sw_clr_ovf),
    .sw_clr_drn_i (sw_clr_drn),
    .dma_sel_i    (cfg_drn_dma_i),
    .ovf_ie_i     (cfg_ovf_ie_i),
    .drn_ie_i     (cfg_drn_ie_i),
    .ovf_flag_o   (ovf_flag),
    .drn_flag_o   (drn_flag),
    .ovf_irq_o    (ovf_irq_o),
    .drn_irq_o    (drn_irq_o),
    .drn_dma_o    (drn_dma_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_en_i && !reg_we_i) begin
      if (reg_addr_i) reg_rdata_o = 32'(head_data);
      else            reg_rdata_o = stat_word(rd_ptr, cnt, drn_flag, ovf_flag);
    end
  end

  assign comb_irq_o = ovf_irq_o | (ext_unf_i & cfg_unf_ie_i) | (ext_tor_i & cfg_tor_ie_i);
endmodule

// File: rtl/res_fifo_chk.sv
module res_fifo_chk
  import res_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic store_req,
  input logic store_acc,
  input logic pop_req,
  input logic pop_acc,
  input logic full,
  input cnt_t cnt,
  input cnt_t rd_ptr,
  input logic ovf_flag,
  input logic drn_flag,
  input logic cfg_drn_dma_i,
  input logic drn_irq_o,
  input logic drn_dma_o
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cnt_t'(DEPTH)); // R1
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && full) |=> ovf_flag); // R2
  AST_OVF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && full && !pop_req) |=> $stable(cnt)); // R2
  AST_DRN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    store_acc |=> drn_flag); // R5
  AST_DRN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drn_irq_o, drn_dma_o})); // R6
  AST_DMA_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_drn_dma_i && pop_acc && !store_acc && cnt == cnt_t'(1)) |=> !drn_flag); // R7
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !store_acc) |=> cnt == cnt_t'($past(cnt) - 1'b1)); // R8
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && rd_ptr == cnt_t'(DEPTH - 1)) |=> rd_ptr == '0); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt == '0 && !store_req) |=> ($stable(cnt) && $stable(rd_ptr))); // R12
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (store_acc && pop_acc) |=> $stable(cnt)); // R12
endmodule

bind res_fifo_top res_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .store_req     (store_req),
  .store_acc     (store_acc),
  .pop_req       (pop_req),
  .pop_acc       (pop_acc),
  .full          (full),
  .cnt           (cnt),
  .rd_ptr        (rd_ptr),
  .ovf_flag      (ovf_flag),
  .drn_flag      (drn_flag),
  .cfg_drn_dma_i (cfg_drn_dma_i),
  .drn_irq_o     (drn_irq_o),
  .drn_dma_o     (drn_dma_o)
);

// File: tb/res_fifo_top_tb_top.sv
module res_fifo_top_tb_top;
  localparam int DEPTH = 4;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_wr = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic reg_en = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ovf_ie = 1'b1, drn_ie = 1'b1, dma = 1'b0, unf_ie = 1'b0, tor_ie = 1'b0;
  logic ext_unf = 1'b0, ext_tor = 1'b0;
  logic ovf_irq, drn_irq, drn_dma, comb_irq;

  always #5 clk = ~clk;

  res_fifo_top #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .res_wr_i(res_wr), .res_data_i(res_data),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_be_i(reg_be),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cfg_ovf_ie_i(ovf_ie), .cfg_drn_ie_i(drn_ie), .cfg_drn_dma_i(dma),
    .cfg_unf_ie_i(unf_ie), .cfg_tor_ie_i(tor_ie), .ext_unf_i(ext_unf), .ext_tor_i(ext_tor),
    .ovf_irq_o(ovf_irq), .drn_irq_o(drn_irq), .drn_dma_o(drn_dma), .comb_irq_o(comb_irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mq[$];
  int mptr = 0;
  logic movf = 1'b0, mdrn = 1'b0;
  logic [DW-1:0] nxt_val = 16'hA000;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] be_pat(int k);
    case (k % 4)
      0: return 4'b0001;
      1: return 4'b0011;
      2: return 4'b1111;
      default: return 4'b0100;
    endcase
  endfunction

  task automatic clr_bus();
    res_wr = 1'b0; reg_en = 1'b0; reg_we = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic op(bit push, bit pop, logic [3:0] be, string req);
    logic full_pre;
    logic [DW-1:0] exp;
    @(negedge clk);
    res_wr = push; res_data = nxt_val;
    reg_en = pop; reg_we = 1'b0; reg_addr = 1'b1; reg_be = be;
    #1;
    if (pop && be != 0) begin
      exp = (mq.size() == 0) ? '0 : mq[0];
      chk(req, reg_rdata, 32'(exp));
    end
    full_pre = (mq.size() == DEPTH);
    if (pop && be != 0 && mq.size() > 0) begin
      void'(mq.pop_front());
      mptr = (mptr + 1) % DEPTH;
    end
    if (push && full_pre) movf = 1'b1;
    if (push && !full_pre) begin
      mq.push_back(nxt_val);
      mdrn = 1'b1;
    end else if (dma && mq.size() == 0) mdrn = 1'b0;
    if (push) nxt_val = nxt_val + 16'h0111;
    @(posedge clk); #1;
    clr_bus();
  endtask

  task automatic stat_wr(logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = 1'b0; reg_be = be; reg_wdata = d;
    if (be[0] && d[0]) movf = 1'b0;
    if (be[0] && d[1] && !dma) mdrn = 1'b0;
    @(posedge clk); #1;
    clr_bus();
  endtask

  task automatic stat_chk(string req);
    logic [31:0] exp;
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = 1'b0; reg_be = 4'hF;
    #1;
    exp = {16'h0, 4'(mptr), 4'(mq.size()), 6'h0, mdrn, movf};
    chk(req, reg_rdata, exp);
    chk({req, " R4 ovf_irq"}, 32'(ovf_irq), 32'(movf & ovf_ie));
    chk({req, " R6 drn_irq"}, 32'(drn_irq), 32'(mdrn & drn_ie & ~dma));
    chk({req, " R6 drn_dma"}, 32'(drn_dma), 32'(mdrn & drn_ie & dma));
    @(posedge clk); #1;
    clr_bus();
  endtask

  task automatic comb_sweep();
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      {ovf_ie, unf_ie, tor_ie, ext_unf, ext_tor} = 5'(c);
      #1;
      chk("R11 comb", 32'(comb_irq),
          32'((movf & ovf_ie) | (ext_unf & unf_ie) | (ext_tor & tor_ie)));
      chk("R4 ovf_irq", 32'(ovf_irq), 32'(movf & ovf_ie));
    end
    @(negedge clk);
    ovf_ie = 1'b1; unf_ie = 1'b0; tor_ie = 1'b0; ext_unf = 1'b0; ext_tor = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    stat_chk("R1 reset");
    chk("R1 reset comb", 32'(comb_irq), 32'h0);

    for (int m = 0; m < 2; m++) begin
      dma = m[0];
      for (int n = 0; n <= DEPTH + 2; n++) begin
        for (int k = 0; k < n; k++) op(1'b1, 1'b0, 4'h0, "R1");
        stat_chk("R1 R2 R5 fill");
        if (n > 0) begin
          stat_wr(32'h2, 4'h1);
          stat_chk("R7 drain clear by write");
          stat_wr(32'hFFFF_FF00, 4'hF);
          stat_chk("R10 ignored field write");
        end
        for (int k = 0; k <= n; k++) begin
          op(1'b0, 1'b1, be_pat(k + n), "R8 R9 R12 pop data");
          stat_chk("R7 R8 R9 R12 after pop");
        end
        stat_wr(32'h0, 4'hF);
        stat_chk("R3 write zero");
        stat_wr(32'h3, 4'h1);
        stat_chk("R3 R7 clear");
      end
    end

    dma = 1'b0;
    op(1'b1, 1'b1, 4'hF, "R12 empty collide");
    stat_chk("R12 empty collide status");
    op(1'b1, 1'b0, 4'h0, "R1");
    op(1'b1, 1'b1, 4'h2, "R12 collide");
    stat_chk("R12 collide status");
    while (mq.size() < DEPTH) op(1'b1, 1'b0, 4'h0, "R1");
    op(1'b1, 1'b1, 4'h8, "R2 full collide");
    stat_chk("R2 full collide status");
    comb_sweep();
    stat_wr(32'h1, 4'h1);
    stat_chk("R3 clear");
    comb_sweep();
    while (mq.size() > 0) op(1'b0, 1'b1, 4'hF, "R8 drain");
    stat_chk("R8 R9 final");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule